// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block is the 256-location internal data store of an 8-bit microcontroller core. Its low 128 bytes hold four banks of eight working registers, a 16-byte bit-addressable region and general-purpose RAM. Its upper 128 direct addresses form a window of special-function-register bytes, modelled here as plain storage. An optional upper RAM array of 128 bytes can be reached only through pointers.

One byte read port and one byte write port each take an access mode that tells how the address is read:

- **Register-number access** goes through the current bank.
- **Direct access** uses the address as given.
- **Indirect access** goes through working register 0 or 1 of the current bank.

A separate bit read port and bit write port take an 8-bit bit address. That address is split between the RAM bit region and the bit-addressable register bytes. A bank register, loaded from dedicated inputs, selects the working-register bank.

The core fetching instructions drives the ports directly. Reads return data one cycle after the request. A bit write changes exactly one bit of the byte that holds it, in a single cycle.

Top module: `regbank_dmem`

## Requirements
- R1: After synchronous reset, the bank register is 0, every byte at direct addresses 00h–FFh reads 00h, and `rd_data` and `bit_rd_val` are 0.
- R2: When `bank_load` is high, the bank register takes `bank_val` at the next edge. A register-number access (mode code 0) with register number n in `addr[2:0]` reaches byte bank×8 + n.
- R3: A direct access (mode code 1, and the reserved code 3) reaches byte `addr` itself. Addresses 00h–7Fh are internal RAM and 80h–FFh are the register window, and all 256 bytes hold independent values.
- R4: A bit address b below 80h refers to byte 20h + b[6:3], bit b[2:0].
- R5: A bit address b of 80h or above refers to byte {b[7:3],000b}, bit b[2:0].
- R6: A bit write sets the addressed bit to `bit_wr_val` and leaves the other seven bits of that byte unchanged.
- R7: An indirect access (mode code 2) uses working register 0 (`addr[0]`=0) or 1 (`addr[0]`=1) of the current bank as the pointer. A pointer below 80h reaches internal RAM at that address.
- R8: An indirect pointer of 80h or above reaches the upper RAM array at pointer[6:0] and never the register window. With `HAS_UPPER`=0, such reads return 00h and such writes have no effect.
- R9: Byte and bit reads present their data one cycle after the request. The data is the stored value from before any write in the same cycle. The outputs hold while no read is requested.
- R10: When a byte write and a bit write hit the same byte in the same cycle, the byte takes the write data with the addressed bit replaced by `bit_wr_val`.
- R11: A register-number access in the same cycle as a bank load uses the bank that was in force before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_load | input | 1 | Load the bank register |
| bank_val | input | 2 | New bank number |
| rd_en | input | 1 | Byte read request |
| rd_mode | input | 2 | Read access mode: 0 register, 1 direct, 2 indirect, 3 direct |
| rd_addr | input | 8 | Read address, register number or pointer select |
| rd_data | output | 8 | Registered read data |
| wr_en | input | 1 | Byte write request |
| wr_mode | input | 2 | Write access mode, same codes as rd_mode |
| wr_addr | input | 8 | Write address, register number or pointer select |
| wr_data | input | 8 | Write data |
| bit_rd_en | input | 1 | Bit read request |
| bit_rd_addr | input | 8 | Bit address to read |
| bit_rd_val | output | 1 | Registered bit read value |
| bit_wr_en | input | 1 | Bit write request |
| bit_wr_addr | input | 8 | Bit address to write |
| bit_wr_val | input | 1 | Value written to the bit |

## Verification
The hardest situations to reach are the ones where two paths meet in one cycle.

- **Shared byte:** a byte write and a bit write land on the same byte, for example a byte write of 00h to 22h together with a bit write to bit address 15h.
- **Read during write:** a read of a location is requested while that location is being written.
- **Bank change:** a register-number write is issued while the bank register is being reloaded.

The bench drives each of these port combinations deliberately in a single cycle. Indirect accesses into the upper array need a pointer of 80h or above, so the bench first writes that pointer into register 0 of a chosen bank by a direct write. A second instance built without the upper array receives the same stimulus, so that its zero reads can be checked.

// File: rtl/idm_pkg.sv
package idm_pkg;
  typedef enum logic [1:0] {
    ACC_REG = 2'd0,
    ACC_DIR = 2'd1,
    ACC_IND = 2'd2,
    ACC_RSV = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/idm_addr_resolve.sv
module idm_addr_resolve
  import idm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] ptr0,
  input  logic [ADDR_W-1:0] ptr1,
  output logic [ADDR_W-1:0] idx,
  output logic              upper
);
  localparam int PAD_W = ADDR_W - BANK_W - REG_W;

  logic [ADDR_W-1:0] ptr;

  always_comb begin
    ptr   = addr[0] ? ptr1 : ptr0;
    idx   = addr;
    upper = 1'b0;
    case (acc_mode_e'(mode))
      ACC_REG: idx = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
      ACC_IND: begin
        idx   = {1'b0, ptr[ADDR_W-2:0]};
        upper = ptr[ADDR_W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idm_bit_map.sv
module idm_bit_map #(
  parameter int                ADDR_W   = 8,
  parameter int                BP_W     = 3,
  parameter logic [ADDR_W-1:0] BIT_BASE = 'h20
) (
  input  logic [ADDR_W-1:0] baddr,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [BP_W-1:0]   pos
);
  localparam int OFS_W = ADDR_W - 1 - BP_W;

  logic [OFS_W-1:0] ofs;

  assign ofs      = baddr[ADDR_W-2:BP_W];
  assign pos      = baddr[BP_W-1:0];
  assign byte_idx = baddr[ADDR_W-1] ? {baddr[ADDR_W-1:BP_W], {BP_W{1'b0}}}
                                    : BIT_BASE + ADDR_W'(ofs);
endmodule

// File: rtl/idm_upper_ram.sv
module idm_upper_ram #(
  parameter int AW      = 7,
  parameter int DW      = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  generate
    if (PRESENT) begin : g_ram
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end

      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (re) q <= mem[raddr];
      end
    end else begin : g_none
      assign q = '0;
    end
  endgenerate
endmodule

// File: rtl/regbank_dmem.sv
module regbank_dmem #(
  parameter int   ADDR_W    = 8,
  parameter int   DW        = 8,
  parameter int   BANK_W    = 2,
  parameter int   REG_W     = 3,
  parameter logic [ADDR_W-1:0] BIT_BASE = 'h20,
  parameter bit   HAS_UPPER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_load,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              rd_en,
  input  logic [1:0]        rd_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              bit_rd_en,
  input  logic [ADDR_W-1:0] bit_rd_addr,
  output logic              bit_rd_val,
  input  logic              bit_wr_en,
  input  logic [ADDR_W-1:0] bit_wr_addr,
  input  logic              bit_wr_val
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - 1;
  localparam int BP_W  = $clog2(DW);
  localparam int PAD_W = ADDR_W - BANK_W - REG_W;

  logic [BANK_W-1:0]          bank_q;
  logic [DEPTH-1:0][DW-1:0]   core_view;
  logic [ADDR_W-1:0]          ptr0, ptr1;
  logic [ADDR_W-1:0]          rd_idx, wr_idx, br_idx, bw_idx;
  logic                       rd_up, wr_up;
  logic [BP_W-1:0]            br_pos, bw_pos;
  logic [DW-1:0]              core_rd_q, up_q;
  logic                       rd_up_q;
  logic                       wr_core;

  always_ff @(posedge clk) begin
    if (rst)            bank_q <= '0;
    else if (bank_load) bank_q <= bank_val;
  end

  assign ptr0 = core_view[{{PAD_W{1'b0}}, bank_q, REG_W'(0)}];
  assign ptr1 = core_view[{{PAD_W{1'b0}}, bank_q, REG_W'(1)}];

  idm_addr_resolve #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_rd_res (
    .mode(rd_mode), .addr(rd_addr), .bank(bank_q), .ptr0(ptr0), .ptr1(ptr1),
    .idx(rd_idx), .upper(rd_up)
  );

  idm_addr_resolve #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_wr_res (
    .mode(wr_mode), .addr(wr_addr), .bank(bank_q), .ptr0(ptr0), .ptr1(ptr1),
    .idx(wr_idx), .upper(wr_up)
  );

  idm_bit_map #(.ADDR_W(ADDR_W), .BP_W(BP_W), .BIT_BASE(BIT_BASE)) u_br_map (
    .baddr(bit_rd_addr), .byte_idx(br_idx), .pos(br_pos)
  );

  idm_bit_map #(.ADDR_W(ADDR_W), .BP_W(BP_W), .BIT_BASE(BIT_BASE)) u_bw_map (
    .baddr(bit_wr_addr), .byte_idx(bw_idx), .pos(bw_pos)
  );

  assign wr_core = wr_en && !wr_up;

  // Core cells: byte write first, bit write merged on top (R10)
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DW-1:0] cell_q, cell_d;

      always_comb begin
        cell_d = cell_q;
        if (wr_core && wr_idx == ADDR_W'(i)) cell_d = wr_data;
        if (bit_wr_en && bw_idx == ADDR_W'(i)) cell_d[bw_pos] = bit_wr_val;
      end

      always_ff @(posedge clk) begin
        if (rst) cell_q <= '0;
        else     cell_q <= cell_d;
      end

      assign core_view[i] = cell_q;
    end
  endgenerate

  idm_upper_ram #(.AW(UP_W), .DW(DW), .PRESENT(HAS_UPPER)) u_upper (
    .clk(clk), .rst(rst),
    .we(wr_en && wr_up), .waddr(wr_idx[UP_W-1:0]), .wdata(wr_data),
    .re(rd_en && rd_up), .raddr(rd_idx[UP_W-1:0]), .q(up_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rd_q  <= '0;
      rd_up_q    <= 1'b0;
      bit_rd_val <= 1'b0;
    end else begin
      if (rd_en) begin
        core_rd_q <= core_view[rd_idx];
        rd_up_q   <= rd_up;
      end
      if (bit_rd_en) bit_rd_val <= core_view[br_idx][br_pos];
    end
  end

  assign rd_data = rd_up_q ? up_q : core_rd_q;
endmodule

// File: rtl/idm_checker.sv
module idm_checker #(
  parameter int BANK_W    = 2,
  parameter int DW        = 8,
  parameter bit HAS_UPPER = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_load,
  input logic [BANK_W-1:0] bank_val,
  input logic [BANK_W-1:0] bank_q,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic              bit_rd_en,
  input logic              bit_rd_val,
  input logic              rd_up_q
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !bit_rd_val && bank_q == '0));

  a_r2_bank_load: assert property (@(posedge clk) disable iff (rst)
    bank_load |=> bank_q == $past(bank_val));

  a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !bank_load |=> $stable(bank_q));

  a_r9_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r9_bit_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_rd_en |=> $stable(bit_rd_val));

  generate
    if (!HAS_UPPER) begin : g_no_upper
      a_r8_absent_zero: assert property (@(posedge clk) disable iff (rst)
        rd_up_q |-> rd_data == '0);
    end
  endgenerate
endmodule

bind regbank_dmem idm_checker #(.BANK_W(BANK_W), .DW(DW), .HAS_UPPER(HAS_UPPER)) u_chk (
  .clk(clk), .rst(rst), .bank_load(bank_load), .bank_val(bank_val),
  .bank_q(bank_q), .rd_en(rd_en), .rd_data(rd_data),
  .bit_rd_en(bit_rd_en), .bit_rd_val(bit_rd_val), .rd_up_q(rd_up_q)
);

// File: tb/regbank_dmem_bench.sv
module regbank_dmem_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       bank_load;
  logic [1:0] bank_val;
  logic       rd_en;
  logic [1:0] rd_mode;
  logic [7:0] rd_addr;
  logic [7:0] rd_data, rd_data_bare;
  logic       wr_en;
  logic [1:0] wr_mode;
  logic [7:0] wr_addr, wr_data;
  logic       bit_rd_en;
  logic [7:0] bit_rd_addr;
  logic       bit_rd_val, bit_rd_val_bare;
  logic       bit_wr_en;
  logic [7:0] bit_wr_addr;
  logic       bit_wr_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  regbank_dmem u_regbank_dmem (
    .clk(clk), .rst(rst), .bank_load(bank_load), .bank_val(bank_val),
    .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_rd_en(bit_rd_en), .bit_rd_addr(bit_rd_addr), .bit_rd_val(bit_rd_val),
    .bit_wr_en(bit_wr_en), .bit_wr_addr(bit_wr_addr), .bit_wr_val(bit_wr_val)
  );

  regbank_dmem #(.HAS_UPPER(1'b0)) u_regbank_dmem_bare (
    .clk(clk), .rst(rst), .bank_load(bank_load), .bank_val(bank_val),
    .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data_bare),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_rd_en(bit_rd_en), .bit_rd_addr(bit_rd_addr), .bit_rd_val(bit_rd_val_bare),
    .bit_wr_en(bit_wr_en), .bit_wr_addr(bit_wr_addr), .bit_wr_val(bit_wr_val)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; bit_rd_en = 1'b0; bit_wr_en = 1'b0; bank_load = 1'b0;
  endtask

  task automatic load_bank(input logic [1:0] b);
    bank_load = 1'b1; bank_val = b; step();
  endtask

  task automatic wr_byte(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_mode = m; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd_byte(input logic [1:0] m, input logic [7:0] a, output logic [7:0] q);
    rd_en = 1'b1; rd_mode = m; rd_addr = a; step(); q = rd_data;
  endtask

  function automatic logic [7:0] bit_byte(input logic [7:0] b);
    return b[7] ? {b[7:3], 3'b000} : 8'h20 + {4'h0, b[6:3]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [7:0] bb;
    logic       nv;

    rst = 1'b1; bank_load = 1'b0; bank_val = '0;
    rd_en = 1'b0; rd_mode = '0; rd_addr = '0;
    wr_en = 1'b0; wr_mode = '0; wr_addr = '0; wr_data = '0;
    bit_rd_en = 1'b0; bit_rd_addr = '0; bit_wr_en = 1'b0; bit_wr_addr = '0; bit_wr_val = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", rd_data, 8'h00, "rd_data after reset");
    chk("R1", {7'd0, bit_rd_val}, 8'h00, "bit_rd_val after reset");
    for (int a = 0; a < 256; a++) begin
      rd_byte(2'd1, 8'(a), q);
      chk("R1", q, 8'h00, $sformatf("byte %h after reset", a));
    end
    // R1 + R2: reset bank is 0, register 5 lands at 05h
    wr_byte(2'd0, 8'h05, 8'h6B); model[8'h05] = 8'h6B;
    rd_byte(2'd1, 8'h05, q);
    chk("R2", q, 8'h6B, "reset bank register write");

    // R3: direct sweep of all 256 bytes
    for (int a = 0; a < 256; a++) begin
      model[a] = 8'((a * 37 + 11) ^ 8'h5A);
      wr_byte(2'd1, 8'(a), model[a]);
    end
    for (int a = 0; a < 256; a++) begin
      rd_byte((a % 2 == 0) ? 2'd1 : 2'd3, 8'(a), q);
      chk("R3", q, model[a], $sformatf("direct byte %h", a));
    end

    // R2: register-number access in every bank
    for (int b = 0; b < 4; b++) begin
      load_bank(2'(b));
      for (int n = 0; n < 8; n++) begin
        model[b * 8 + n] = 8'(8'hC3 ^ (b * 16 + n * 3));
        wr_byte(2'd0, 8'(n), model[b * 8 + n]);
      end
      for (int n = 0; n < 8; n++) begin
        rd_byte(2'd0, 8'(n | 8'hA8), q);
        chk("R2", q, model[b * 8 + n], $sformatf("bank %0d reg %0d", b, n));
      end
    end
    for (int a = 0; a < 32; a++) begin
      rd_byte(2'd1, 8'(a), q);
      chk("R2", q, model[a], $sformatf("bank area byte %h", a));
    end

    // R4 / R5: bit read sweep
    for (int b = 0; b < 256; b++) begin
      bit_rd_en = 1'b1; bit_rd_addr = 8'(b); step();
      bb = bit_byte(8'(b));
      chk(b < 128 ? "R4" : "R5", {7'd0, bit_rd_val}, {7'd0, model[bb][b % 8]},
          $sformatf("bit address %h", b));
    end

    // R6: bit write read-modify-write
    for (int b = 0; b < 256; b += 7) begin
      bb = bit_byte(8'(b));
      nv = ~model[bb][b % 8];
      bit_wr_en = 1'b1; bit_wr_addr = 8'(b); bit_wr_val = nv; step();
      model[bb][b % 8] = nv;
      rd_byte(2'd1, bb, q);
      chk("R6", q, model[bb], $sformatf("byte %h after bit write %h", bb, b));
    end

    // R7: indirect through R0 / R1 of the current bank
    load_bank(2'd2);
    wr_byte(2'd1, 8'h10, 8'h45); model[8'h10] = 8'h45;
    wr_byte(2'd1, 8'h11, 8'h7E); model[8'h11] = 8'h7E;
    wr_byte(2'd2, 8'h00, 8'hA5); model[8'h45] = 8'hA5;
    rd_byte(2'd1, 8'h45, q);
    chk("R7", q, 8'hA5, "indirect write via R0");
    rd_byte(2'd2, 8'h01, q);
    chk("R7", q, model[8'h7E], "indirect read via R1");
    load_bank(2'd3);
    wr_byte(2'd1, 8'h18, 8'h33); model[8'h18] = 8'h33;
    rd_byte(2'd2, 8'h00, q);
    chk("R7", q, model[8'h33], "indirect follows bank 3 R0");

    // R8: pointers at 80h and above go to the upper array
    wr_byte(2'd1, 8'h18, 8'h90); model[8'h18] = 8'h90;
    wr_byte(2'd1, 8'h19, 8'hFF); model[8'h19] = 8'hFF;
    wr_byte(2'd2, 8'h00, 8'h3C);
    wr_byte(2'd2, 8'h01, 8'hE1);
    rd_byte(2'd1, 8'h90, q);
    chk("R8", q, model[8'h90], "register window untouched by upper write");
    rd_byte(2'd1, 8'hFF, q);
    chk("R8", q, model[8'hFF], "register byte FFh untouched");
    rd_byte(2'd2, 8'h00, q);
    chk("R8", q, 8'h3C, "upper array via R0");
    chk("R8", rd_data_bare, 8'h00, "absent upper array reads zero");
    rd_byte(2'd2, 8'h01, q);
    chk("R8", q, 8'hE1, "upper array via R1");
    chk("R8", rd_data_bare, 8'h00, "absent upper array reads zero R1");
    rd_byte(2'd1, 8'h10, q);
    chk("R8", rd_data_bare, model[8'h10], "bare instance direct read");

    // R9: read during write returns the old value
    rd_en = 1'b1; rd_mode = 2'd1; rd_addr = 8'h40;
    wr_en = 1'b1; wr_mode = 2'd1; wr_addr = 8'h40; wr_data = 8'h99;
    step();
    chk("R9", rd_data, model[8'h40], "read during write");
    model[8'h40] = 8'h99;
    rd_byte(2'd1, 8'h40, q);
    chk("R9", q, 8'h99, "read after write");
    step();
    chk("R9", rd_data, 8'h99, "rd_data holds while idle");

    // R10: byte and bit write to byte 22h in one cycle
    wr_en = 1'b1; wr_mode = 2'd1; wr_addr = 8'h22; wr_data = 8'h00;
    bit_wr_en = 1'b1; bit_wr_addr = 8'h15; bit_wr_val = 1'b1;
    step();
    model[8'h22] = 8'h20;
    rd_byte(2'd1, 8'h22, q);
    chk("R10", q, 8'h20, "merged byte and bit write");

    // R11: bank load and register write in the same cycle
    load_bank(2'd1);
    bank_load = 1'b1; bank_val = 2'd2;
    wr_en = 1'b1; wr_mode = 2'd0; wr_addr = 8'h06; wr_data = 8'h5D;
    step();
    model[8'h0E] = 8'h5D;
    rd_byte(2'd1, 8'h0E, q);
    chk("R11", q, 8'h5D, "write used old bank 1");
    rd_byte(2'd1, 8'h16, q);
    chk("R11", q, model[8'h16], "new bank 2 register untouched");
    rd_byte(2'd0, 8'h06, q);
    chk("R11", q, model[8'h16], "new bank in force after load");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule